// File: doc/BRIEF.md
# Service Bridge Control Register File

This block holds the configuration and status words of a processor service bridge as a bank of 64-bit registers. Two independent request ports reach it. One is a side-band configuration port that sees the whole register space. The other is a memory-mapped port whose index space starts at the base-address register. Every access moves a full 8-byte word. A read answers one cycle after its request. Illegal accesses produce a one-cycle error pulse on the port that made them.

Besides plain storage, the block applies per-register write rules. These are write-only AND/OR aliases of the fault register, set/clear aliases of the control word, masked address registers, and a status word that software cannot write. The block decodes the enable bit and base address of the bridge's own register window and exports them. Logic outside the block uses these to place the window in the address map.

Top module: `svc_bridge_regs`

## Requirements
- R1: After reset every register reads zero, except the base-address register (index 0x0a), which reads BAR_RST OR 1. `region_en` is 1 and `region_base` equals BAR_RST.
- R2: On the side-band port the register index is byte address >> 3. On the memory-mapped port it is (byte address >> 3) + 0x0a, so memory-mapped address 0x00 reaches the base-address register and 0x20 reaches control (index 0x0e).
- R3: A request that a port presents at a rising edge is answered after that edge. `*_rvalid` is high for exactly that one cycle for a read, and stays low for a write. `*_err` is high for that one cycle when the access is illegal.
- R4: A write to index 0x01 sets fault = fault AND data, and a write to index 0x02 sets fault = fault OR data (fault is index 0x00). Reads of 0x01 and 0x02 return all ones.
- R5: A write to index 0x12 sets control = control OR data, and a write to index 0x13 sets control = control AND NOT data. Reads of both aliases return all ones.
- R6: A side-band write to index 0x0a stores data AND 0x0003fffffff00001. `region_en` equals stored bit 0, and `region_base` equals the stored value AND 0x0003fffffff00000.
- R7: A memory-mapped write to the base-address register leaves it unchanged and raises `mm_err`. A memory-mapped read of it is legal.
- R8: A write to the secondary base register (index 0x0b) stores data AND 0x0003ffff00000000.
- R9: The status register (index 0x15) reads the value `stat_in` had at the previous rising edge. A write to it changes nothing and raises the port's error pulse.
- R10: A read of an index with no register returns all ones without error. A write to such an index changes nothing and raises the error pulse.
- R11: An access whose size is not 8 bytes, or whose address bits [2:0] are not zero, changes nothing, raises the error pulse, and returns all ones if it is a read.
- R12: When both ports request in the same cycle, the side-band access is performed. The memory-mapped access is refused: it has no effect, raises `mm_err`, and returns all ones if it is a read.
- R13: Indices 0x00, 0x06, 0x07, 0x0e, 0x0f and 0x14 store and return all 64 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_req | input | 1 | Side-band request strobe |
| sc_we | input | 1 | Side-band write (1) or read (0) |
| sc_addr | input | ADDR_W | Side-band byte address |
| sc_size | input | 4 | Side-band access size in bytes |
| sc_wdata | input | 64 | Side-band write data |
| sc_rvalid | output | 1 | Side-band read answer valid |
| sc_rdata | output | 64 | Side-band read data |
| sc_err | output | 1 | Side-band illegal-access pulse |
| mm_req | input | 1 | Memory-mapped request strobe |
| mm_we | input | 1 | Memory-mapped write (1) or read (0) |
| mm_addr | input | ADDR_W | Memory-mapped byte address |
| mm_size | input | 4 | Memory-mapped access size in bytes |
| mm_wdata | input | 64 | Memory-mapped write data |
| mm_rvalid | output | 1 | Memory-mapped read answer valid |
| mm_rdata | output | 64 | Memory-mapped read data |
| mm_err | output | 1 | Memory-mapped illegal-access pulse |
| stat_in | input | 64 | Interrupt status source word |
| region_en | output | 1 | Register window enabled |
| region_base | output | 64 | Register window base address |

## Verification
The bench builds the block with ADDR_W = 8 and BAR_RST = 0x0001234567800000. The 8-bit address puts the top of the side-band index space (index 31) in reach, as well as memory-mapped indices above the last register, so the all-ones answer can be checked at the edges of the map. The reset value lies inside the base-address mask and has enable-off bits nowhere. Its reset read therefore separates the masked field from the enable bit, and the exported base can be compared bit for bit.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  localparam int unsigned WORD_W    = 64;
  localparam int unsigned ACC_BYTES = 8;

  localparam logic [WORD_W-1:0] BAR_KEEP  = 64'h0003_ffff_fff0_0000;
  localparam logic [WORD_W-1:0] BAR_ON    = 64'h0000_0000_0000_0001;
  localparam logic [WORD_W-1:0] BAR2_KEEP = 64'h0003_ffff_0000_0000;
  localparam logic [WORD_W-1:0] ALL_ONES  = {WORD_W{1'b1}};

  // register indices (the memory-mapped bias depends on IX_BAR)
  localparam int unsigned IX_FIR     = 'h00;
  localparam int unsigned IX_FIR_AND = 'h01;
  localparam int unsigned IX_FIR_OR  = 'h02;
  localparam int unsigned IX_ACT0    = 'h06;
  localparam int unsigned IX_ACT1    = 'h07;
  localparam int unsigned IX_BAR     = 'h0a;
  localparam int unsigned IX_BAR2    = 'h0b;
  localparam int unsigned IX_CTL     = 'h0e;
  localparam int unsigned IX_EMASK   = 'h0f;
  localparam int unsigned IX_CTL_SET = 'h12;
  localparam int unsigned IX_CTL_CLR = 'h13;
  localparam int unsigned IX_DMAUP   = 'h14;
  localparam int unsigned IX_STAT    = 'h15;

  localparam int unsigned PORT_SC = 0;
  localparam int unsigned PORT_MM = 1;
  localparam int unsigned NPORT   = 2;

  typedef enum logic [3:0] {
    S_NONE, S_FIR, S_FIR_AND, S_FIR_OR, S_ACT0, S_ACT1, S_BAR, S_BAR2,
    S_CTL, S_EMASK, S_CTL_SET, S_CTL_CLR, S_DMAUP, S_STAT
  } rsel_e;

  typedef struct packed {
    logic  rd;
    logic  wr;
    rsel_e sel;
    logic  err;
  } acc_s;

  typedef struct packed {
    logic [WORD_W-1:0] fir;
    logic [WORD_W-1:0] act0;
    logic [WORD_W-1:0] act1;
    logic [WORD_W-1:0] bar;
    logic [WORD_W-1:0] bar2;
    logic [WORD_W-1:0] ctl;
    logic [WORD_W-1:0] emask;
    logic [WORD_W-1:0] dmaup;
  } cfg_s;

endpackage

// File: rtl/sbr_port_dec.sv
module sbr_port_dec
  import sbr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned IDX_BIAS  = 0,
  parameter bit          BAR_WR_OK = 1'b1
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  output acc_s              acc
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  rsel_e            sel;
  logic             shape_ok;
  logic             wr_ok;

  assign idx = IDX_W'(addr[ADDR_W-1:3]) + IDX_W'(IDX_BIAS);

  always_comb begin
    case (idx)
      IDX_W'(IX_FIR):     sel = S_FIR;
      IDX_W'(IX_FIR_AND): sel = S_FIR_AND;
      IDX_W'(IX_FIR_OR):  sel = S_FIR_OR;
      IDX_W'(IX_ACT0):    sel = S_ACT0;
      IDX_W'(IX_ACT1):    sel = S_ACT1;
      IDX_W'(IX_BAR):     sel = S_BAR;
      IDX_W'(IX_BAR2):    sel = S_BAR2;
      IDX_W'(IX_CTL):     sel = S_CTL;
      IDX_W'(IX_EMASK):   sel = S_EMASK;
      IDX_W'(IX_CTL_SET): sel = S_CTL_SET;
      IDX_W'(IX_CTL_CLR): sel = S_CTL_CLR;
      IDX_W'(IX_DMAUP):   sel = S_DMAUP;
      IDX_W'(IX_STAT):    sel = S_STAT;
      default:            sel = S_NONE;
    endcase
  end

  assign shape_ok = (size == 4'(ACC_BYTES)) && (addr[2:0] == 3'b000);

  always_comb begin
    wr_ok = 1'b1;
    if (sel == S_NONE || sel == S_STAT) wr_ok = 1'b0;
    if (sel == S_BAR && !BAR_WR_OK)     wr_ok = 1'b0;
  end

  assign acc.rd  = req & ~we & shape_ok;
  assign acc.wr  = req & we & shape_ok & wr_ok;
  assign acc.sel = sel;
  assign acc.err = req & (~shape_ok | (we & ~wr_ok));

endmodule

// File: rtl/sbr_rd_mux.sv
module sbr_rd_mux
  import sbr_pkg::*;
(
  input  cfg_s              cfg,
  input  logic [WORD_W-1:0] stat,
  input  rsel_e             sel,
  output logic [WORD_W-1:0] data
);

  always_comb begin
    case (sel)
      S_FIR:   data = cfg.fir;
      S_ACT0:  data = cfg.act0;
      S_ACT1:  data = cfg.act1;
      S_BAR:   data = cfg.bar;
      S_BAR2:  data = cfg.bar2;
      S_CTL:   data = cfg.ctl;
      S_EMASK: data = cfg.emask;
      S_DMAUP: data = cfg.dmaup;
      S_STAT:  data = stat;
      default: data = ALL_ONES;  // aliases and holes
    endcase
  end

endmodule

// File: rtl/sbr_regfile.sv
module sbr_regfile
  import sbr_pkg::*;
#(
  parameter logic [WORD_W-1:0] BAR_RST = 64'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  rsel_e             wsel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] stat_in,
  output cfg_s              cfg_q,
  output logic [WORD_W-1:0] stat_q
);

  cfg_s cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (wsel)
      S_FIR:     cfg_d.fir   = wdata;
      S_FIR_AND: cfg_d.fir   = cfg_q.fir & wdata;
      S_FIR_OR:  cfg_d.fir   = cfg_q.fir | wdata;
      S_ACT0:    cfg_d.act0  = wdata;
      S_ACT1:    cfg_d.act1  = wdata;
      S_BAR:     cfg_d.bar   = wdata & (BAR_KEEP | BAR_ON);
      S_BAR2:    cfg_d.bar2  = wdata & BAR2_KEEP;
      S_CTL:     cfg_d.ctl   = wdata;
      S_CTL_SET: cfg_d.ctl   = cfg_q.ctl | wdata;
      S_CTL_CLR: cfg_d.ctl   = cfg_q.ctl & ~wdata;
      S_EMASK:   cfg_d.emask = wdata;
      S_DMAUP:   cfg_d.dmaup = wdata;
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cfg_q.bar <= BAR_RST | BAR_ON;
    end else if (wen) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_in;
  end

  // R4: AND alias combines with the old fault word
  p_fir_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wsel == S_FIR_AND) |=> cfg_q.fir == ($past(cfg_q.fir) & $past(wdata)));

  // R5: clear alias removes only the written ones
  p_ctl_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wsel == S_CTL_CLR) |=> cfg_q.ctl == ($past(cfg_q.ctl) & ~$past(wdata)));

  // R6: no stored base bit outside the legal field after a write
  p_bar_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wsel == S_BAR) |=> (cfg_q.bar & ~(BAR_KEEP | BAR_ON)) == '0);

  // R8: secondary base keeps no low bits
  p_bar2_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wen && wsel == S_BAR2) |=> (cfg_q.bar2 & ~BAR2_KEEP) == '0);

endmodule

// File: rtl/svc_bridge_regs.sv
module svc_bridge_regs
  import sbr_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 12,
  parameter int unsigned       MM_BIAS = IX_BAR,
  parameter logic [WORD_W-1:0] BAR_RST = 64'h0000_0006_0300_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_req,
  input  logic              sc_we,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [3:0]        sc_size,
  input  logic [WORD_W-1:0] sc_wdata,
  output logic              sc_rvalid,
  output logic [WORD_W-1:0] sc_rdata,
  output logic              sc_err,
  input  logic              mm_req,
  input  logic              mm_we,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [3:0]        mm_size,
  input  logic [WORD_W-1:0] mm_wdata,
  output logic              mm_rvalid,
  output logic [WORD_W-1:0] mm_rdata,
  output logic              mm_err,
  input  logic [WORD_W-1:0] stat_in,
  output logic              region_en,
  output logic [WORD_W-1:0] region_base
);

  logic [NPORT-1:0]  p_req;
  logic [NPORT-1:0]  p_we;
  logic [ADDR_W-1:0] p_addr  [NPORT];
  logic [3:0]        p_size  [NPORT];
  logic [WORD_W-1:0] p_wdata [NPORT];

  cfg_s              cfg_q;
  logic [WORD_W-1:0] stat_q;
  logic              wen;
  rsel_e             wsel;
  logic [WORD_W-1:0] wdata;

  assign p_req = {mm_req, sc_req};
  assign p_we  = {mm_we, sc_we};
  assign p_addr[PORT_SC]  = sc_addr;
  assign p_addr[PORT_MM]  = mm_addr;
  assign p_size[PORT_SC]  = sc_size;
  assign p_size[PORT_MM]  = mm_size;
  assign p_wdata[PORT_SC] = sc_wdata;
  assign p_wdata[PORT_MM] = mm_wdata;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    acc_s              acc;
    logic [WORD_W-1:0] mux;
    logic              go;
    logic              rv_d, er_d, rv_q, er_q;
    logic [WORD_W-1:0] rd_d, rd_q;

    sbr_port_dec #(
      .ADDR_W   (ADDR_W),
      .IDX_BIAS ((g == PORT_MM) ? MM_BIAS : 0),
      .BAR_WR_OK(g == PORT_SC)
    ) u_dec (
      .req (p_req[g]),
      .we  (p_we[g]),
      .addr(p_addr[g]),
      .size(p_size[g]),
      .acc (acc)
    );

    sbr_rd_mux u_mux (
      .cfg (cfg_q),
      .stat(stat_q),
      .sel (acc.sel),
      .data(mux)
    );

    // side-band always wins a same-cycle clash
    if (g == PORT_SC) begin : g_win
      assign go = 1'b1;
    end else begin : g_yield
      assign go = ~p_req[PORT_SC];
    end

    always_comb begin
      rv_d = p_req[g] & ~p_we[g];
      er_d = acc.err | (p_req[g] & ~go);
      rd_d = (acc.rd & go) ? mux : ALL_ONES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rv_q <= 1'b0;
        er_q <= 1'b0;
        rd_q <= '0;
      end else begin
        rv_q <= rv_d;
        er_q <= er_d;
        if (rv_d) rd_q <= rd_d;
      end
    end
  end

  always_comb begin
    wen   = 1'b0;
    wsel  = S_NONE;
    wdata = '0;
    if (g_port[PORT_SC].acc.wr) begin
      wen   = 1'b1;
      wsel  = g_port[PORT_SC].acc.sel;
      wdata = sc_wdata;
    end else if (g_port[PORT_MM].acc.wr && g_port[PORT_MM].go) begin
      wen   = 1'b1;
      wsel  = g_port[PORT_MM].acc.sel;
      wdata = p_wdata[PORT_MM];
    end
  end

  sbr_regfile #(.BAR_RST(BAR_RST)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wen    (wen),
    .wsel   (wsel),
    .wdata  (wdata),
    .stat_in(stat_in),
    .cfg_q  (cfg_q),
    .stat_q (stat_q)
  );

  assign sc_rvalid   = g_port[PORT_SC].rv_q;
  assign sc_err      = g_port[PORT_SC].er_q;
  assign sc_rdata    = g_port[PORT_SC].rd_q;
  assign mm_rvalid   = g_port[PORT_MM].rv_q;
  assign mm_err      = g_port[PORT_MM].er_q;
  assign mm_rdata    = g_port[PORT_MM].rd_q;
  assign region_en   = cfg_q.bar[0];
  assign region_base = cfg_q.bar & BAR_KEEP;

  // R3: a read is answered in the next cycle, and only a read
  p_rvalid_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !sc_we) |=> sc_rvalid);
  p_norvalid_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sc_req && !sc_we) |=> !sc_rvalid);

  // R7: memory-mapped base write leaves the window untouched
  p_bar_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && mm_we && !sc_req && mm_size == 4'(ACC_BYTES) &&
     mm_addr == ADDR_W'((IX_BAR - MM_BIAS) * 8))
    |=> (mm_err && $stable(region_base) && $stable(region_en)));

  // R11: wrong size is always flagged
  p_size_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && sc_size != 4'(ACC_BYTES)) |=> sc_err);

  // R12: memory-mapped side loses a clash
  p_clash_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && mm_req) |=> mm_err);

endmodule

// File: tb/test_svc_bridge_regs.sv
module test_svc_bridge_regs;
  import sbr_pkg::*;

  localparam int unsigned       AW   = 8;
  localparam logic [63:0]       BRST = 64'h0001_2345_6780_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sc_req = 0, sc_we = 0, mm_req = 0, mm_we = 0;
  logic [AW-1:0] sc_addr = '0, mm_addr = '0;
  logic [3:0]    sc_size = 4'd8, mm_size = 4'd8;
  logic [63:0]   sc_wdata = '0, mm_wdata = '0, stat_in = '0;
  logic          sc_rvalid, sc_err, mm_rvalid, mm_err, region_en;
  logic [63:0]   sc_rdata, mm_rdata, region_base;

  always #10 clk = ~clk;  // 50 MHz

  svc_bridge_regs #(.ADDR_W(AW), .BAR_RST(BRST)) i_svc_bridge_regs (
    .clk, .rst_n,
    .sc_req, .sc_we, .sc_addr, .sc_size, .sc_wdata, .sc_rvalid, .sc_rdata, .sc_err,
    .mm_req, .mm_we, .mm_addr, .mm_size, .mm_wdata, .mm_rvalid, .mm_rdata, .mm_err,
    .stat_in, .region_en, .region_base
  );

  typedef struct packed {
    int          due;
    logic        rv;
    logic        er;
    logic [63:0] d;
  } exp_t;

  exp_t  q_sc[$], q_mm[$];
  string t_sc[$], t_mm[$];
  int    cyc = 0;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_sc(logic we, logic [AW-1:0] a, logic [63:0] d, logic [3:0] sz,
                        logic erv, logic eer, logic [63:0] ed, string tag);
    sc_req = 1; sc_we = we; sc_addr = a; sc_wdata = d; sc_size = sz;
    q_sc.push_back('{due: cyc + 1, rv: erv, er: eer, d: ed});
    t_sc.push_back(tag);
  endtask

  task automatic put_mm(logic we, logic [AW-1:0] a, logic [63:0] d, logic [3:0] sz,
                        logic erv, logic eer, logic [63:0] ed, string tag);
    mm_req = 1; mm_we = we; mm_addr = a; mm_wdata = d; mm_size = sz;
    q_mm.push_back('{due: cyc + 1, rv: erv, er: eer, d: ed});
    t_mm.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    sc_req = 0; sc_we = 0; sc_size = 4'd8;
    mm_req = 0; mm_we = 0; mm_size = 4'd8;
  endtask

  // shorthands: read expecting data, write expecting ok/err
  task automatic rd_sc(logic [AW-1:0] a, logic [63:0] ed, string tag);
    put_sc(0, a, '0, 4'd8, 1, 0, ed, tag); tick();
  endtask
  task automatic wr_sc(logic [AW-1:0] a, logic [63:0] d, logic eer, string tag);
    put_sc(1, a, d, 4'd8, 0, eer, '0, tag); tick();
  endtask
  task automatic rd_mm(logic [AW-1:0] a, logic [63:0] ed, string tag);
    put_mm(0, a, '0, 4'd8, 1, 0, ed, tag); tick();
  endtask
  task automatic wr_mm(logic [AW-1:0] a, logic [63:0] d, logic eer, string tag);
    put_mm(1, a, d, 4'd8, 0, eer, '0, tag); tick();
  endtask

  task automatic mon_port(string pn, logic rv, logic er, logic [63:0] rd, bit is_sc);
    exp_t  e;
    string tg;
    bit    have;
    have = is_sc ? (q_sc.size() > 0 && q_sc[0].due == cyc)
                 : (q_mm.size() > 0 && q_mm[0].due == cyc);
    if (have) begin
      if (is_sc) begin e = q_sc.pop_front(); tg = t_sc.pop_front(); end
      else       begin e = q_mm.pop_front(); tg = t_mm.pop_front(); end
      n_cmp++;
      if (rv !== e.rv || er !== e.er || (e.rv && rd !== e.d)) begin
        n_bad++;
        $display("FAIL %s %s actual rv=%b err=%b data=%h expected rv=%b err=%b data=%h",
                 tg, pn, rv, er, rd, e.rv, e.er, e.d);
      end
    end else if (rv !== 1'b0 || er !== 1'b0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3 %s unexpected pulse actual rv=%b err=%b expected rv=0 err=0",
               pn, rv, er);
    end
  endtask

  // scoreboard monitor, sampling 5 ns after each rising edge
  always begin
    @(posedge clk);
    #5;
    if (rst_n && !done) begin
      mon_port("sc", sc_rvalid, sc_err, sc_rdata, 1'b1);
      mon_port("mm", mm_rvalid, mm_err, mm_rdata, 1'b0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 region_en", {63'b0, region_en}, 64'd1);
    chk("R1 region_base", region_base, BRST);
    chk("R1 rvalid/err idle", {62'b0, sc_rvalid, sc_err}, 64'd0);
    rd_sc(8'h00, 64'h0, "R1 fault reset");
    rd_sc(8'h50, BRST | 64'h1, "R1 base reset");
    rd_sc(8'h70, 64'h0, "R1 control reset");
    rd_sc(8'hA8, 64'h0, "R1 status reset");

    // R13 full-width storage, R2 indexing on both ports
    wr_sc(8'h00, 64'hA5A5_0000_FFFF_1234, 0, "R13 fault write");
    rd_sc(8'h00, 64'hA5A5_0000_FFFF_1234, "R13 fault read");
    wr_sc(8'h30, 64'h0123_4567_89AB_CDEF, 0, "R13 act0 write");
    wr_sc(8'h38, 64'hFEDC_BA98_7654_3210, 0, "R13 act1 write");
    rd_sc(8'h30, 64'h0123_4567_89AB_CDEF, "R13 act0 read");
    rd_sc(8'h38, 64'hFEDC_BA98_7654_3210, "R13 act1 read");
    wr_mm(8'h28, 64'hDEAD_BEEF_0BAD_F00D, 0, "R2 mm emask write");
    rd_sc(8'h78, 64'hDEAD_BEEF_0BAD_F00D, "R2 emask via side-band");
    wr_mm(8'h50, 64'h0000_00FF_FF00_0000, 0, "R2 mm dma write");
    rd_sc(8'hA0, 64'h0000_00FF_FF00_0000, "R13 dma via side-band");
    rd_mm(8'h28, 64'hDEAD_BEEF_0BAD_F00D, "R2 mm emask read");

    // R4 fault aliases
    wr_sc(8'h08, 64'hFF00_FF00_FF00_FF00, 0, "R4 AND alias");
    rd_sc(8'h00, 64'hA500_0000_FF00_1200, "R4 after AND");
    wr_sc(8'h10, 64'h0000_0000_0000_00FF, 0, "R4 OR alias");
    rd_sc(8'h00, 64'hA500_0000_FF00_12FF, "R4 after OR");
    rd_sc(8'h08, ALL_ONES, "R4 AND alias reads ones");

    // R5 control set/clear via memory-mapped port
    wr_mm(8'h20, 64'h8000_0000_0000_0000, 0, "R5 control write");
    wr_mm(8'h40, 64'h0400_0000_0000_0001, 0, "R5 set alias");
    rd_mm(8'h20, 64'h8400_0000_0000_0001, "R5 after set");
    wr_mm(8'h48, 64'h8000_0000_0000_0000, 0, "R5 clear alias");
    rd_sc(8'h70, 64'h0400_0000_0000_0001, "R5 after clear");
    rd_sc(8'h98, ALL_ONES, "R5 clear alias reads ones");

    // R6 base register from side-band
    wr_sc(8'h50, ALL_ONES, 0, "R6 base write ones");
    chk("R6 region_en", {63'b0, region_en}, 64'd1);
    chk("R6 region_base", region_base, 64'h0003_ffff_fff0_0000);
    rd_sc(8'h50, 64'h0003_ffff_fff0_0001, "R6 base masked");
    wr_sc(8'h50, 64'h0000_0000_0040_0000, 0, "R6 base disable");
    chk("R6 region_en off", {63'b0, region_en}, 64'd0);
    chk("R6 region_base", region_base, 64'h0000_0000_0040_0000);

    // R7 memory-mapped base write refused
    wr_mm(8'h00, 64'h0000_0000_1230_0001, 1, "R7 mm base write");
    chk("R7 region_en kept", {63'b0, region_en}, 64'd0);
    chk("R7 region_base kept", region_base, 64'h0000_0000_0040_0000);
    rd_mm(8'h00, 64'h0000_0000_0040_0000, "R7 mm base read");

    // R8 secondary base
    wr_mm(8'h08, ALL_ONES, 0, "R8 secondary write");
    rd_sc(8'h58, 64'h0003_ffff_0000_0000, "R8 secondary masked");

    // R9 status register
    stat_in = 64'h0000_0012_3400_5678;
    tick();
    rd_sc(8'hA8, 64'h0000_0012_3400_5678, "R9 status tracks input");
    wr_sc(8'hA8, ALL_ONES, 1, "R9 status write refused");
    rd_mm(8'h58, 64'h0000_0012_3400_5678, "R9 status unchanged");

    // R10 holes
    rd_sc(8'h18, ALL_ONES, "R10 hole read");
    wr_sc(8'h18, 64'h1, 1, "R10 hole write");
    rd_sc(8'hF8, ALL_ONES, "R10 top index read");
    rd_mm(8'hF8, ALL_ONES, "R10 mm hole read");
    rd_sc(8'h00, 64'hA500_0000_FF00_12FF, "R10 fault untouched");

    // R11 bad size / alignment
    put_sc(1, 8'h00, 64'h0, 4'd4, 0, 1, '0, "R11 short write"); tick();
    rd_sc(8'h00, 64'hA500_0000_FF00_12FF, "R11 fault untouched");
    put_sc(0, 8'h00, 64'h0, 4'd4, 1, 1, ALL_ONES, "R11 short read"); tick();
    put_mm(1, 8'h24, 64'h0, 4'd8, 0, 1, '0, "R11 misaligned write"); tick();
    rd_mm(8'h20, 64'h0400_0000_0000_0001, "R11 control untouched");

    // R12 clash
    put_sc(1, 8'h70, 64'h1111_0000_0000_0000, 4'd8, 0, 0, '0, "R12 sc wins");
    put_mm(1, 8'h20, 64'h2222_0000_0000_0000, 4'd8, 0, 1, '0, "R12 mm refused");
    tick();
    put_sc(0, 8'h70, '0, 4'd8, 1, 0, 64'h1111_0000_0000_0000, "R12 sc read");
    put_mm(0, 8'h20, '0, 4'd8, 1, 1, ALL_ONES, "R12 mm read refused");
    tick();

    repeat (3) tick();
    chk("R3 scoreboard drained", 64'(q_sc.size() + q_mm.size()), 64'd0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule